// File: doc/BRIEF.md
# Triangle Down-Spread Modulation Generator

This block produces the digital profile for spread-spectrum clocking in a frequency synthesizer. It runs on the reference clock. While the spread enable is set, it outputs a signed offset word that moves in a symmetric triangle. Each period starts at zero, falls step by step to a depth set by the spread fraction and the nominal feedback divider value, then climbs back to zero. A downstream fractional feedback divider adds this word to its control, so the synthesized frequency only ever moves below nominal.

A prescaler divides the reference clock by `PRESCALE` (16) to make a step tick. A three-state machine walks a level counter through one period of `2*HALF_STEPS` ticks (32 ticks, 512 reference clocks). The three states are:

- `PH_REST`: the zero point at the period boundary.
- `PH_SINK`: the deviation is growing.
- `PH_RISE`: the deviation is shrinking.

The state transitions are:

- **start** (`PH_REST`→`PH_SINK`): on a tick with enable high. This transition also captures the peak depth from the divider value.
- **turn** (`PH_SINK`→`PH_RISE`): on the tick taken at full depth.
- **close** (`PH_RISE`→`PH_REST`): on the tick taken at level 1.
- **park**: `PH_REST` stays in `PH_REST` on a tick with enable low.

A scaler turns the captured peak and the current level into the registered offset word. The word has 8 fractional bits.

Top module: `ssc_tri_mod`

## Requirements
- R1: During reset and after it, with `ssc_on` low, `spread_off` is 0.
- R2: Every nonzero offset value is held for exactly `PRESCALE` = 16 reference clocks before the next value appears.
- R3: One modulation period lasts 32 step ticks (512 reference clocks) while `ssc_on` stays high. Within it, levels 1..16 are followed by levels 15..1 and then one tick at 0. The next period begins immediately after that zero tick.
- R4: The peak depth is P = floor(M × 256 × 5 / 1000), where M is `m_div` and the spread is 5 per mille with 8 fractional bits. At level 16 the output equals −P. For M = 192 that is −245.
- R5: At level k the output is −floor(P × k / 16). Falling and rising levels of the same k give the same value.
- R6: `spread_off` is never positive.
- R7: When `ssc_on` is cleared mid-period, the current period runs to its end, and the output then stays 0.
- R8: `m_div` is sampled only at the start of a period. A change during a period leaves that period's values unchanged and takes effect from the next period.
- R9: When `ssc_on` rises while the generator is at rest, the first nonzero offset appears within 17 reference clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ssc_on | input | 1 | Spread-spectrum enable |
| m_div | input | 9 | Nominal feedback divider value M |
| spread_off | output | 11 | Signed offset word, 8 fractional bits, never positive |

## Verification
Whole periods are run with several divider values: 192, 240, 120 and 511. These show whether the peak scaling and the per-step truncation follow the formula, rather than a fixed table or a wrong rounding. Each period is sampled on every clock, so a plateau that is too short or too long, a missing turn or an off-by-one period length all show up as a misaligned value. A divider change during a period tells sampling at the period boundary apart from continuous sampling. Clearing the enable mid-period tells an immediate stop apart from completing the period before going quiet.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        PH_REST = 2'd0,
        PH_SINK = 2'd1,
        PH_RISE = 2'd2
    } phase_e;

    localparam int unsigned PER_MILLE_DEN = 1000;

endpackage

// File: rtl/ssc_tick_gen.sv
module ssc_tick_gen #(
    parameter int unsigned PRESCALE = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE == 1) begin : g_bypass
            assign tick = 1'b1;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == CNT_W'(PRESCALE - 1)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == CNT_W'(PRESCALE - 1));

            // R2: ticks are isolated, never two in a row
            assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ssc_profile_fsm.sv
module ssc_profile_fsm
    import ssc_pkg::*;
#(
    parameter int unsigned HALF_STEPS = 16,
    localparam int unsigned LVL_W = $clog2(HALF_STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    output logic [LVL_W-1:0] level,
    output logic             capture
);
    phase_e           state_q, state_nx;
    logic [LVL_W-1:0] level_q, level_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_REST;
            level_q <= '0;
        end else begin
            state_q <= state_nx;
            level_q <= level_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        level_nx = level_q;
        capture  = 1'b0;
        unique case (state_q)
            PH_REST: begin
                if (tick && enable) begin
                    state_nx = PH_SINK;
                    level_nx = LVL_W'(1);
                    capture  = 1'b1;
                end
            end
            PH_SINK: begin
                if (tick) begin
                    if (level_q == LVL_W'(HALF_STEPS)) begin
                        state_nx = PH_RISE;
                        level_nx = LVL_W'(HALF_STEPS - 1);
                    end else begin
                        level_nx = level_q + 1'b1;
                    end
                end
            end
            PH_RISE: begin
                if (tick) begin
                    if (level_q == LVL_W'(1)) begin
                        state_nx = PH_REST;
                        level_nx = '0;
                    end else begin
                        level_nx = level_q - 1'b1;
                    end
                end
            end
            default: begin
                state_nx = PH_REST;
                level_nx = '0;
            end
        endcase
    end

    assign level = level_q;

    // R4: the level never goes past full depth
    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LVL_W'(HALF_STEPS));

    // R2: the level only moves on a step tick
    assert_level_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level_q));

    // R3: full depth is followed by the rising half
    assert_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SINK && tick && level_q == LVL_W'(HALF_STEPS)) |=> (state_q == PH_RISE));

    // R7: at rest with enable low the level stays at zero
    assert_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_REST && !enable) |=> (level_q == '0));

endmodule

// File: rtl/ssc_depth_scaler.sv
module ssc_depth_scaler
    import ssc_pkg::*;
#(
    parameter int unsigned M_W              = 9,
    parameter int unsigned FRAC_W           = 8,
    parameter int unsigned SPREAD_PER_MILLE = 5,
    parameter int unsigned HALF_STEPS       = 16,
    localparam int unsigned LVL_W  = $clog2(HALF_STEPS + 1),
    localparam int unsigned PEAK_W = M_W + FRAC_W - 7,
    localparam int unsigned OFF_W  = PEAK_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic [M_W-1:0]          m_val,
    input  logic [LVL_W-1:0]        level,
    output logic signed [OFF_W-1:0] offset
);
    localparam int unsigned SCALE   = SPREAD_PER_MILLE << FRAC_W;
    localparam int unsigned PROD_W  = M_W + $clog2(SCALE + 1);
    localparam int unsigned STEP_SH = $clog2(HALF_STEPS);
    localparam int unsigned DEPTH_W = PEAK_W + LVL_W;

    logic [PROD_W-1:0]       prod;
    logic [PEAK_W-1:0]       peak_nx, peak_q;
    logic [DEPTH_W-1:0]      depth_full;
    logic [PEAK_W-1:0]       depth;
    logic signed [OFF_W-1:0] off_q;

    always_comb begin
        prod       = PROD_W'(m_val) * PROD_W'(SCALE);
        peak_nx    = PEAK_W'(prod / PROD_W'(PER_MILLE_DEN));
        depth_full = DEPTH_W'(peak_q) * DEPTH_W'(level);
        depth      = depth_full[STEP_SH +: PEAK_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peak_q <= '0;
            off_q  <= '0;
        end else begin
            if (capture) begin
                peak_q <= peak_nx;
            end
            off_q <= OFF_W'(0) - $signed({1'b0, depth});
        end
    end

    assign offset = off_q;

    // R6: the spread is downward only
    assert_never_positive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= 0);

    // R8: the captured depth only changes at a period start
    assert_peak_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(peak_q));

endmodule

// File: rtl/ssc_tri_mod.sv
module ssc_tri_mod #(
    parameter int unsigned M_W              = 9,
    parameter int unsigned FRAC_W           = 8,
    parameter int unsigned SPREAD_PER_MILLE = 5,
    parameter int unsigned PRESCALE         = 16,
    parameter int unsigned HALF_STEPS       = 16
) (
    input  logic                               clk_ref,
    input  logic                               rst_n,
    input  logic                               ssc_on,
    input  logic [M_W-1:0]                     m_div,
    output logic signed [M_W+FRAC_W-7:0]       spread_off
);
    localparam int unsigned LVL_W = $clog2(HALF_STEPS + 1);

    logic             tick;
    logic             capture;
    logic [LVL_W-1:0] level;

    ssc_tick_gen #(
        .PRESCALE (PRESCALE)
    ) u_tick (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ssc_profile_fsm #(
        .HALF_STEPS (HALF_STEPS)
    ) u_fsm (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .tick    (tick),
        .enable  (ssc_on),
        .level   (level),
        .capture (capture)
    );

    ssc_depth_scaler #(
        .M_W              (M_W),
        .FRAC_W           (FRAC_W),
        .SPREAD_PER_MILLE (SPREAD_PER_MILLE),
        .HALF_STEPS       (HALF_STEPS)
    ) u_scale (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .capture (capture),
        .m_val   (m_div),
        .level   (level),
        .offset  (spread_off)
    );

    // R1: a zero level yields a zero offset one clock later
    assert_zero_at_rest_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (level == '0) |=> (spread_off == 0));

endmodule

// File: tb/ssc_tri_mod_tb.sv
module ssc_tri_mod_tb_top;

    logic              clk_ref = 1'b0;
    logic              rst_n   = 1'b0;
    logic              ssc_on  = 1'b0;
    logic [8:0]        m_div   = 9'd192;
    logic signed [10:0] spread_off;

    int checks   = 0;
    int failures = 0;
    int positives = 0;

    always #4 clk_ref = ~clk_ref;

    ssc_tri_mod dut_i (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .ssc_on     (ssc_on),
        .m_div      (m_div),
        .spread_off (spread_off)
    );

    always @(negedge clk_ref) begin
        if (rst_n && spread_off > 0) positives++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int peak_of(input int m);
        return (m * 256 * 5) / 1000;
    endfunction

    function automatic int step_val(input int m, input int k);
        return -((peak_of(m) * k) / 16);
    endfunction

    // R1: reset value and idle behaviour
    task automatic t_reset();
        int bad = 0;
        @(negedge clk_ref);
        chk(spread_off == 0, "R1 during reset", spread_off, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk_ref);
            if (spread_off != 0) bad++;
        end
        chk(bad == 0, "R1 idle after reset", bad, 0);
    endtask

    // R9: start latency from rest
    task automatic t_start(input int m);
        int n = 0;
        m_div  = 9'(m);
        ssc_on = 1'b1;
        @(negedge clk_ref);
        n = 1;
        while (spread_off == 0 && n < 40) begin
            @(negedge clk_ref);
            n++;
        end
        chk(n <= 17 && spread_off != 0, "R9 start latency", n, 17);
    endtask

    // R2 R3 R4 R5 (plus R7/R8 via stop_at / newm_at)
    task automatic t_period(input int m, input int stop_at, input int newm_at, input int newm);
        int w = 0;
        while (spread_off == 0 && w < 1100) begin
            @(negedge clk_ref);
            w++;
        end
        chk(spread_off != 0, "R3 period start", spread_off, step_val(m, 1));
        for (int p = 0; p < 31; p++) begin
            int lvl = (p < 16) ? p + 1 : 31 - p;
            int exp = step_val(m, lvl);
            int bad = 0;
            int act = exp;
            for (int s = 0; s < 16; s++) begin
                if (!(p == 0 && s == 0)) @(negedge clk_ref);
                if (spread_off != exp) begin
                    bad++;
                    act = spread_off;
                end
            end
            if (p == 15)
                chk(bad == 0, "R4 peak depth", act, exp);
            else
                chk(bad == 0, "R2 R5 plateau value", act, exp);
            if (p == stop_at) ssc_on = 1'b0;
            if (p == newm_at) m_div = 9'(newm);
        end
        begin
            int bad = 0;
            for (int s = 0; s < 16; s++) begin
                @(negedge clk_ref);
                if (spread_off != 0) bad++;
            end
            chk(bad == 0, "R3 boundary zero tick", bad, 0);
        end
        @(negedge clk_ref);
        if (ssc_on)
            chk(spread_off != 0, "R3 period length 512", spread_off, -1);
        else
            chk(spread_off == 0, "R7 no restart", spread_off, 0);
    endtask

    // R7: disable mid-period, then quiet
    task automatic t_stop_mid(input int m);
        int bad = 0;
        t_period(m, 20, -1, 0);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk_ref);
            if (spread_off != 0) bad++;
        end
        chk(bad == 0, "R7 quiet after stop", bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk_ref);
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_start(192);
        t_period(192, -1, 8, 240);   // R8: mid-period change has no effect now
        t_period(240, -1, -1, 0);    // R8: new value applies next period
        m_div = 9'd120;
        t_period(240, -1, -1, 0);    // R8: 120 captured at the following start
        m_div = 9'd511;
        t_period(120, -1, -1, 0);
        t_stop_mid(511);
        chk(positives == 0, "R6 never positive", positives, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule